// File: doc/BRIEF.md
# Integer Computational ALU with Instruction Decode

This block is the integer execute stage of a 32-bit load/store core, reduced to its combinational core. The caller presents a full 32-bit instruction word together with the two source operand values already read from the register file. The block recognises the two integer computational opcodes, the register-register group and the register-immediate group. It selects the second operand, either the `rs2` value or the sign-extended 12-bit immediate. It works out the shift distance and computes the result in the same cycle.

Instruction bit 30 does two jobs. In the register group it turns an addition into a subtraction. In both groups it turns a logical right shift into an arithmetic one. In the immediate group it never changes an addition. Shift distances come only from the low bits of `rs2` or of the immediate field. The number of bits used is log2 of the data width: 5 at 32, 6 at 64, 7 at 128.

A `valid` output flags a legal encoding. For any encoding that is not legal, `valid` is low and the result is held at zero, so the downstream writeback logic can simply gate on `valid`.

Top module: `rv_int_alu`

## Requirements
- R1: Only opcode `instr[6:0]` = 0110011 (register group) or 0010011 (immediate group) can be legal; any other opcode drives `valid` low and `result` to zero.
- R2: In the register group with funct3 (`instr[14:12]`) = 000, bit 30 clear gives `rs1 + rs2` and bit 30 set (funct7 = 0100000) gives `rs1 - rs2`, modulo 2^32.
- R3: For funct3 = 101 in either group, bit 30 clear fills vacated high bits with zero and bit 30 set fills them with the sign bit of `rs1`.
- R4: Register-group shifts (funct3 001 left, 101 right) use only `rs2[4:0]` as the distance; the upper bits of `rs2` have no effect on `result`.
- R5: Immediate-group shifts use `instr[24:20]` as the distance.
- R6: Immediate-group funct3 000, 010, 011, 100, 110 and 111 use `instr[31:20]` sign-extended to 32 bits, and funct3 000 always adds, whatever bit 30 holds.
- R7: funct3 010 compares signed, funct3 011 compares unsigned (first operand below second gives 1, otherwise 0), in both groups.
- R8: In the register group, funct7 (`instr[31:25]`) = 0000000 is legal for every funct3, 0100000 only for funct3 000 and 101, and any other funct7 is illegal (`valid` low, `result` zero).
- R9: In the immediate group, funct3 001 is legal only with `instr[31:25]` = 0000000, and funct3 101 only with `instr[31]` = 0 and `instr[29:25]` = 00000; illegal ones give `valid` low and `result` zero.
- R10: funct3 100, 110 and 111 give bitwise XOR, OR and AND of the two operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word |
| rs1_val | input | XLEN | First source operand value |
| rs2_val | input | XLEN | Second source operand value (register group only) |
| result | output | XLEN | Computed value, zero when illegal |
| valid | output | 1 | High when the encoding is legal |

## Verification
Bit 30 can act as an operand bit and as an operation select in the same evaluation. For an arithmetic shift-immediate it is both the shift-type select and a bit of the immediate. For an addition-immediate with bit 30 set it must remain only an immediate bit. The sweep crosses every funct3 with funct7 patterns that set and clear bit 30 alone and together with other bits, in both groups and on invalid opcodes. Each result and `valid` is judged against an arithmetic model that does shifts by multiplication and division, and signed compares by offsetting the sign bit.

// File: rtl/rvalu_pkg.sv
package rvalu_pkg;

    typedef enum logic [3:0] {
        OP_ADD,
        OP_SUB,
        OP_SLL,
        OP_SLT,
        OP_SLTU,
        OP_XOR,
        OP_SRL,
        OP_SRA,
        OP_OR,
        OP_AND
    } alu_op_e;

    localparam logic [6:0] OPC_REG = 7'b0110011;
    localparam logic [6:0] OPC_IMM = 7'b0010011;

    localparam logic [6:0] F7_BASE = 7'b0000000;
    localparam logic [6:0] F7_ALT  = 7'b0100000;

endpackage

// File: rtl/rvalu_decode.sv
module rvalu_decode
    import rvalu_pkg::*;
#(
    parameter int SHW = 5
) (
    input  logic [6:0]  opcode,
    input  logic [2:0]  funct3,
    input  logic [11:0] imm12,
    output alu_op_e     op,
    output logic        use_imm,
    output logic        legal
);

    logic [6:0] funct7;
    logic       bit30;
    logic       f7_base;
    logic       f7_alt;
    logic       sh_upper_zero;
    logic       sh_nonflag_zero;

    assign funct7          = imm12[11:5];
    assign bit30           = imm12[10];
    assign f7_base         = (funct7 == F7_BASE);
    assign f7_alt          = (funct7 == F7_ALT);
    assign sh_upper_zero   = (imm12[11:SHW] == '0);
    assign sh_nonflag_zero = (imm12[11] == 1'b0) && (imm12[9:SHW] == '0);

    always_comb begin
        op      = OP_ADD;
        use_imm = 1'b0;
        legal   = 1'b0;
        if (opcode == OPC_REG) begin
            legal = f7_base;
            unique case (funct3)
                3'b000: begin
                    op    = bit30 ? OP_SUB : OP_ADD;
                    legal = f7_base | f7_alt;
                end
                3'b001: op = OP_SLL;
                3'b010: op = OP_SLT;
                3'b011: op = OP_SLTU;
                3'b100: op = OP_XOR;
                3'b101: begin
                    op    = bit30 ? OP_SRA : OP_SRL;
                    legal = f7_base | f7_alt;
                end
                3'b110: op = OP_OR;
                3'b111: op = OP_AND;
                default: op = OP_ADD;
            endcase
        end else if (opcode == OPC_IMM) begin
            use_imm = 1'b1;
            legal   = 1'b1;
            unique case (funct3)
                3'b000: op = OP_ADD;
                3'b001: begin
                    op    = OP_SLL;
                    legal = sh_upper_zero;
                end
                3'b010: op = OP_SLT;
                3'b011: op = OP_SLTU;
                3'b100: op = OP_XOR;
                3'b101: begin
                    op    = bit30 ? OP_SRA : OP_SRL;
                    legal = sh_nonflag_zero;
                end
                3'b110: op = OP_OR;
                3'b111: op = OP_AND;
                default: op = OP_ADD;
            endcase
        end
    end

endmodule

// File: rtl/rvalu_operand.sv
module rvalu_operand #(
    parameter int XLEN = 32,
    parameter int SHW  = 5
) (
    input  logic [11:0]     imm12,
    input  logic [XLEN-1:0] rs2_val,
    input  logic            use_imm,
    output logic [XLEN-1:0] opb,
    output logic [SHW-1:0]  shamt
);

    logic [XLEN-1:0] imm_ext;

    assign imm_ext = {{(XLEN-12){imm12[11]}}, imm12};
    assign opb     = use_imm ? imm_ext : rs2_val;
    assign shamt   = use_imm ? imm12[SHW-1:0] : rs2_val[SHW-1:0];

endmodule

// File: rtl/rvalu_exec.sv
module rvalu_exec
    import rvalu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int SHW  = 5
) (
    input  alu_op_e         op,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic [SHW-1:0]  shamt,
    output logic [XLEN-1:0] res
);

    logic lt_signed;
    logic lt_unsigned;

    assign lt_signed   = $signed(opa) < $signed(opb);
    assign lt_unsigned = opa < opb;

    always_comb begin
        unique case (op)
            OP_ADD:  res = opa + opb;
            OP_SUB:  res = opa - opb;
            OP_SLL:  res = opa << shamt;
            OP_SLT:  res = {{(XLEN-1){1'b0}}, lt_signed};
            OP_SLTU: res = {{(XLEN-1){1'b0}}, lt_unsigned};
            OP_XOR:  res = opa ^ opb;
            OP_SRL:  res = opa >> shamt;
            OP_SRA:  res = $unsigned($signed(opa) >>> shamt);
            OP_OR:   res = opa | opb;
            OP_AND:  res = opa & opb;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/rv_int_alu.sv
module rv_int_alu
    import rvalu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] rs2_val,
    output logic [XLEN-1:0] result,
    output logic            valid
);

    localparam int SHW = $clog2(XLEN);

    alu_op_e         op;
    logic            use_imm;
    logic            legal;
    logic [XLEN-1:0] opb;
    logic [SHW-1:0]  shamt;
    logic [XLEN-1:0] raw_res;
    logic            unused_fields;

    assign unused_fields = ^{instr[19:15], instr[11:7]};

    rvalu_decode #(.SHW(SHW)) u_decode (
        .opcode  (instr[6:0]),
        .funct3  (instr[14:12]),
        .imm12   (instr[31:20]),
        .op      (op),
        .use_imm (use_imm),
        .legal   (legal)
    );

    rvalu_operand #(.XLEN(XLEN), .SHW(SHW)) u_operand (
        .imm12   (instr[31:20]),
        .rs2_val (rs2_val),
        .use_imm (use_imm),
        .opb     (opb),
        .shamt   (shamt)
    );

    rvalu_exec #(.XLEN(XLEN), .SHW(SHW)) u_exec (
        .op      (op),
        .opa     (rs1_val),
        .opb     (opb),
        .shamt   (shamt),
        .res     (raw_res)
    );

    assign result = legal ? raw_res : '0;
    assign valid  = legal;

endmodule

// File: rtl/rv_int_alu_checker.sv
module rv_int_alu_checker #(
    parameter int XLEN = 32
) (
    input logic [31:0]     instr,
    input logic [XLEN-1:0] rs1_val,
    input logic [XLEN-1:0] rs2_val,
    input logic [XLEN-1:0] result,
    input logic            valid
);

    localparam int SHW = $clog2(XLEN);

    logic is_reg;
    logic is_imm;
    logic known;

    assign is_reg = (instr[6:0] == 7'b0110011);
    assign is_imm = (instr[6:0] == 7'b0010011);
    assign known  = !$isunknown({instr, rs1_val, rs2_val, result, valid});

    always_comb begin
        if (known) begin
            if (!is_reg && !is_imm)
                assert_other_opcode_R1: assert (!valid && result == '0);
            if (is_reg && instr[31:25] != 7'h00 && instr[31:25] != 7'h20)
                assert_reg_funct7_R8: assert (!valid && result == '0);
            if (is_imm && instr[14:12] == 3'b001 && instr[31:25] != 7'h00)
                assert_slli_funct7_R9: assert (!valid);
            if (is_imm && instr[14:12] == 3'b000)
                assert_addi_legal_R6: assert (valid);
            if (valid && (instr[14:12] == 3'b010 || instr[14:12] == 3'b011))
                assert_cmp_bool_R7: assert (result[XLEN-1:1] == '0);
            if (valid && instr[14:12] == 3'b101 && !rs1_val[XLEN-1])
                assert_rshift_pos_R3: assert (!result[XLEN-1]);
            if (valid && is_reg && instr[14:12] == 3'b001 && rs2_val[SHW-1:0] == '0)
                assert_sll_zero_dist_R4: assert (result == rs1_val);
        end
    end

endmodule

bind rv_int_alu rv_int_alu_checker #(.XLEN(XLEN)) u_checker (
    .instr   (instr),
    .rs1_val (rs1_val),
    .rs2_val (rs2_val),
    .result  (result),
    .valid   (valid)
);

// File: tb/rv_int_alu_bench.sv
module rv_int_alu_bench;

    logic        clk = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs1_val = '0;
    logic [31:0] rs2_val = '0;
    logic [31:0] result;
    logic        valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rv_int_alu #(.XLEN(32)) u_rv_int_alu (
        .instr   (instr),
        .rs1_val (rs1_val),
        .rs2_val (rs2_val),
        .result  (result),
        .valid   (valid)
    );

    function automatic logic [63:0] pow2(input int n);
        logic [63:0] p = 64'd1;
        for (int i = 0; i < n; i++) p = p * 64'd2;
        return p;
    endfunction

    function automatic logic [31:0] m_sl(input logic [31:0] a, input int n);
        logic [63:0] prod = {32'd0, a} * pow2(n);
        return prod[31:0];
    endfunction

    function automatic logic [31:0] m_srl(input logic [31:0] a, input int n);
        logic [63:0] q = {32'd0, a} / pow2(n);
        return q[31:0];
    endfunction

    function automatic logic [31:0] m_sra(input logic [31:0] a, input int n);
        logic [63:0] q;
        if (a[31]) begin
            q = {32'd0, ~a} / pow2(n);
            return ~q[31:0];
        end
        q = {32'd0, a} / pow2(n);
        return q[31:0];
    endfunction

    function automatic logic m_lts(input logic [31:0] a, input logic [31:0] b);
        return (a ^ 32'h8000_0000) < (b ^ 32'h8000_0000);
    endfunction

    // Reference: returns {valid, result}
    function automatic logic [32:0] model(input logic [31:0] ins,
                                          input logic [31:0] a,
                                          input logic [31:0] r2);
        logic [6:0]  opc = ins[6:0];
        logic [2:0]  f3  = ins[14:12];
        logic [6:0]  f7  = ins[31:25];
        logic [31:0] imm = {{20{ins[31]}}, ins[31:20]};
        logic [31:0] b;
        int          sh;
        logic        ok;
        logic [31:0] r;
        if (opc == 7'b0110011) begin
            b  = r2;
            sh = int'(r2[4:0]);
            ok = (f7 == 7'h00) || (f7 == 7'h20 && (f3 == 3'd0 || f3 == 3'd5));
            case (f3)
                3'd0: r = f7[5] ? a - b : a + b;
                3'd1: r = m_sl(a, sh);
                3'd2: r = {31'd0, m_lts(a, b)};
                3'd3: r = {31'd0, (a < b)};
                3'd4: r = a ^ b;
                3'd5: r = f7[5] ? m_sra(a, sh) : m_srl(a, sh);
                3'd6: r = a | b;
                default: r = a & b;
            endcase
        end else if (opc == 7'b0010011) begin
            b  = imm;
            sh = int'(ins[24:20]);
            ok = 1'b1;
            case (f3)
                3'd0: r = a + b;
                3'd1: begin r = m_sl(a, sh); ok = (f7 == 7'h00); end
                3'd2: r = {31'd0, m_lts(a, b)};
                3'd3: r = {31'd0, (a < b)};
                3'd4: r = a ^ b;
                3'd5: begin
                    r  = ins[30] ? m_sra(a, sh) : m_srl(a, sh);
                    ok = !ins[31] && (ins[29:25] == 5'd0);
                end
                3'd6: r = a | b;
                default: r = a & b;
            endcase
        end else begin
            ok = 1'b0;
            r  = '0;
        end
        if (!ok) r = '0;
        return {ok, r};
    endfunction

    function automatic string tag_for(input logic [31:0] ins, input logic ok);
        logic [6:0] opc = ins[6:0];
        logic [2:0] f3  = ins[14:12];
        if (opc != 7'b0110011 && opc != 7'b0010011) return "R1";
        if (!ok) return (opc == 7'b0110011) ? "R8" : "R9";
        case (f3)
            3'd0: return (opc == 7'b0110011) ? "R2" : "R6";
            3'd1: return (opc == 7'b0110011) ? "R4" : "R5";
            3'd2, 3'd3: return "R7";
            3'd5: return "R3";
            default: return "R10";
        endcase
    endfunction

    task automatic check_val(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s instr=%08h result actual=%08h expected=%08h", req, instr, act, exp);
        end
    endtask

    task automatic check_flag(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s instr=%08h valid actual=%0b expected=%0b", req, instr, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        instr   = ins;
        rs1_val = a;
        rs2_val = b;
        #1;
    endtask

    task automatic run_one(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
        logic [32:0] m;
        string       t;
        apply(ins, a, b);
        m = model(ins, a, b);
        t = tag_for(ins, m[32]);
        check_flag(t, valid, m[32]);
        check_val(t, result, m[31:0]);
    endtask

    function automatic logic [31:0] enc(input logic [6:0] f7, input logic [4:0] r2f,
                                        input logic [2:0] f3, input logic [6:0] opc);
        return {f7, r2f, 5'd17, f3, 5'd12, opc};
    endfunction

    localparam logic [6:0] OREG = 7'b0110011;
    localparam logic [6:0] OIMM = 7'b0010011;

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        logic [6:0]  opc_list [4] = '{7'b0110011, 7'b0010011, 7'b0000011, 7'b0110111};
        logic [6:0]  f7_list  [6] = '{7'h00, 7'h20, 7'h01, 7'h40, 7'h7f, 7'h3f};
        logic [4:0]  r2f_list [5] = '{5'd0, 5'd1, 5'd4, 5'd8, 5'd31};
        logic [31:0] a_list   [6] = '{32'h0000_0000, 32'h1234_5678, 32'h8765_4321,
                                      32'h7654_3210, 32'hffff_ffff, 32'h8000_0000};
        logic [31:0] b_list   [6] = '{32'h0000_0008, 32'hffff_ff08, 32'h8000_0001,
                                      32'h7fff_ffff, 32'h0000_001f, 32'h0000_0000};

        // Idle state: all-zero word has an illegal opcode (R1)
        apply(32'h0, 32'h1234_5678, 32'h1);
        check_flag("R1", valid, 1'b0);
        check_val("R1", result, 32'h0);

        // Worked examples
        apply(enc(7'h00, 5'd0, 3'd1, OREG), 32'h1234_5678, 32'hffff_ff08);
        check_val("R4", result, 32'h3456_7800);
        apply(enc(7'h00, 5'd4, 3'd1, OIMM), 32'h1234_5678, 32'h0);
        check_val("R5", result, 32'h2345_6780);
        apply(enc(7'h20, 5'd0, 3'd5, OREG), 32'h8765_4321, 32'h8);
        check_val("R3", result, 32'hff87_6543);
        apply(enc(7'h00, 5'd0, 3'd5, OREG), 32'h8765_4321, 32'h8);
        check_val("R3", result, 32'h0087_6543);
        apply(enc(7'h20, 5'd0, 3'd5, OREG), 32'h7654_3210, 32'h8);
        check_val("R3", result, 32'h0076_5432);
        apply(enc(7'h00, 5'd0, 3'd5, OREG), 32'h7654_3210, 32'h8);
        check_val("R3", result, 32'h0076_5432);
        apply(enc(7'h20, 5'd4, 3'd5, OIMM), 32'h8765_4321, 32'h0);
        check_val("R3", result, 32'hf876_5432);
        apply(enc(7'h00, 5'd4, 3'd5, OIMM), 32'h8765_4321, 32'h0);
        check_val("R3", result, 32'h0876_5432);
        // addi with bit 30 set: imm = 0x400, still an add
        apply(enc(7'h20, 5'd0, 3'd0, OIMM), 32'h0000_0010, 32'h0);
        check_val("R6", result, 32'h0000_0410);
        check_flag("R6", valid, 1'b1);
        // sub
        apply(enc(7'h20, 5'd0, 3'd0, OREG), 32'h0000_0005, 32'h0000_0007);
        check_val("R2", result, 32'hffff_fffe);
        // slti vs sltiu with imm = -1
        apply(enc(7'h7f, 5'd31, 3'd2, OIMM), 32'h0000_0001, 32'h0);
        check_val("R7", result, 32'h0);
        apply(enc(7'h7f, 5'd31, 3'd3, OIMM), 32'h0000_0001, 32'h0);
        check_val("R7", result, 32'h1);
        // xor with 0x0ff
        apply(enc(7'h07, 5'd31, 3'd4, OIMM), 32'h0000_0f0f, 32'h0);
        check_val("R10", result, 32'h0000_0ff0);

        // Sweep
        for (int io = 0; io < 4; io++)
            for (int f3 = 0; f3 < 8; f3++)
                for (int i7 = 0; i7 < 6; i7++)
                    for (int ir = 0; ir < 5; ir++)
                        for (int ia = 0; ia < 6; ia++)
                            run_one(enc(f7_list[i7], r2f_list[ir], 3'(f3), opc_list[io]),
                                    a_list[ia], b_list[(ia + ir) % 6]);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule